// File: doc/BRIEF.md
# Subnormal-Operand Single-Precision Multiplier

This unit forms the single-precision product of two 32-bit operand words when one of them is subnormal, as needed by a software-assist or fix-up path that finishes multiplications the main floating-point datapath declines. A front-end step reorders the operands so that the subnormal one always enters the core in the first slot. The core then multiplies the first operand's bare fraction by the second operand's fraction with its hidden bit restored. It takes the exponent from the second operand only, and it normalises using the leading-one position of the raw product.

The result is always truncated, never rounded. The core packs either a normal word or a subnormal word, or flushes to a signed zero. The operation is started by a one-cycle `start` pulse. The answer appears with a one-cycle `done` pulse at a fixed latency, and `result` keeps its value until the next operation finishes. NaN and infinity inputs get no special treatment.

Top module: `dnm_fmul`

## Requirements
- R1: The result magnitude (bits 30:0) is zero when, after reordering, the second operand's magnitude (bits 30:0) is below 0x00800000, or the first operand's magnitude is zero.
- R2: When the first input word's magnitude is at least 0x00800000, the two operands are exchanged before the core uses them. Otherwise they keep their order.
- R3: The core multiplies the first operand's 23-bit fraction (bits 22:0, no hidden bit) by the second operand's fraction with bit 23 set. Its base exponent is the second operand's field in bits 30:23. A zero product gives a signed zero.
- R4: Let w be the bit index of the product's leading one. Then the adjusted exponent is base + w − 172. When it is positive, bits 30:23 hold it and bits 22:0 hold the 23 bits just below the leading one.
- R5: When the adjusted exponent e lies in −22..0, the result is subnormal. Bits 30:23 are zero and bits 22:0 are the product shifted right by (w − 22 − e), with a left shift if that count is negative.
- R6: When the adjusted exponent is below −22, the magnitude flushes to zero.
- R7: Bit 31 of every result is the XOR of the two input sign bits (bit 31).
- R8: Product bits below the kept field are discarded, with no rounding.
- R9: An accepted `start` (sampled on a rising edge) raises `busy` from that edge. `done` is high for exactly one cycle after the third rising edge counted from the accepting one, and `result` is valid from that point on.
- R10: A `start` pulse while `busy` is high is ignored. It does not change the pending result and produces no extra `done`.
- R11: Reset clears `busy` and `done`. An operation in flight when reset arrives never signals `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication |
| op_a | input | 32 | First operand word |
| op_b | input | 32 | Second operand word |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Truncated product word |

## Verification
The operands are captured on the rising edge that accepts `start`. The product is registered on that edge, the leading-one position and normalised product on the next, and the packed word on the third. So `done` and `result` are due just after the third rising edge, counting the accepting one. The bench drives inputs and samples outputs on falling edges. It checks `busy` one half-cycle after the accepting edge, checks `done` and `result` exactly after the third edge, and checks on the following falling edge that `done` has dropped. The ignored-start and mid-flight-reset cases also sample `done` at every falling edge of the window in which a wrong pulse could appear.

// File: rtl/dnm_pkg.sv
package dnm_pkg;
  localparam int FRAC_W  = 23;
  localparam int EXP_W   = 8;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MANT_W  = FRAC_W + 1;
  localparam int PROD_W  = FRAC_W + MANT_W;
  localparam int POS_W   = $clog2(PROD_W);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXPS_W  = EXP_W + 2;
  localparam int ADJ_OFS = (BIAS - 1) + 2 * FRAC_W;
  localparam int SUB_MIN = FRAC_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FIND = 2'd1,
    ST_PACK = 2'd2
  } dnm_state_e;
endpackage

// File: rtl/dnm_order.sv
module dnm_order
  import dnm_pkg::*;
(
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  output logic [WORD_W-1:0] first,
  output logic [WORD_W-1:0] second
);
  logic swap;

  // R2: a normal-range first word is moved to the second slot
  always_comb begin
    swap = (in_a[WORD_W-2:0] >= (WORD_W-1)'(1 << FRAC_W));
    if (swap) begin
      first  = in_b;
      second = in_a;
    end else begin
      first  = in_a;
      second = in_b;
    end
  end
endmodule

// File: rtl/dnm_lead_norm.sv
module dnm_lead_norm
  import dnm_pkg::*;
(
  input  logic [PROD_W-1:0] prod,
  output logic              found,
  output logic [POS_W-1:0]  pos,
  output logic [PROD_W-1:0] norm
);
  // Priority encoder: the highest set bit wins
  always_comb begin
    found = |prod;
    pos   = '0;
    for (int i = 0; i < PROD_W; i++) begin
      if (prod[i]) pos = POS_W'(i);
    end
    norm = prod << (POS_W'(PROD_W - 1) - pos);
  end
endmodule

// File: rtl/dnm_pack.sv
module dnm_pack
  import dnm_pkg::*;
(
  input  logic              sgn,
  input  logic              force_zero,
  input  logic              found,
  input  logic [EXP_W-1:0]  base_exp,
  input  logic [POS_W-1:0]  pos,
  input  logic [PROD_W-1:0] norm,
  output logic [WORD_W-1:0] res
);
  logic signed [EXPS_W-1:0] adj;
  logic        [EXPS_W-1:0] neg_adj;
  logic        [POS_W-1:0]  sub_sh;
  logic        [PROD_W-1:0] sub_bits;

  always_comb begin
    adj      = EXPS_W'(base_exp) + EXPS_W'(pos) - EXPS_W'(ADJ_OFS);
    neg_adj  = -adj;
    sub_sh   = POS_W'(MANT_W) + neg_adj[POS_W-1:0];
    sub_bits = norm >> sub_sh;
    if (force_zero || !found) begin
      res = {sgn, {(WORD_W-1){1'b0}}};
    end else if (adj > 0) begin
      // R4: normal result, fraction just below the leading one
      res = {sgn, adj[EXP_W-1:0], norm[PROD_W-2 -: FRAC_W]};
    end else if (adj >= -SUB_MIN) begin
      // R5: subnormal result
      res = {sgn, {EXP_W{1'b0}}, sub_bits[FRAC_W-1:0]};
    end else begin
      // R6: flush
      res = {sgn, {(WORD_W-1){1'b0}}};
    end
  end
endmodule

// File: rtl/dnm_fmul.sv
module dnm_fmul
  import dnm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] result
);
  dnm_state_e        st_q, st_d;
  logic              done_q, done_d;
  logic              load_en, find_en, pack_en;

  logic [WORD_W-1:0] first_w, second_w;
  logic [PROD_W-1:0] prod_d;
  logic              zero_d;

  logic [WORD_W-1:0] a_q, b_q;
  logic [PROD_W-1:0] prod_q;
  logic              zero_q;

  logic              found_w;
  logic [POS_W-1:0]  pos_w;
  logic [PROD_W-1:0] norm_w;
  logic              found_q;
  logic [POS_W-1:0]  pos_q;
  logic [PROD_W-1:0] norm_q;

  logic [WORD_W-1:0] res_w, res_q;

  dnm_order u_order (
    .in_a   (op_a),
    .in_b   (op_b),
    .first  (first_w),
    .second (second_w)
  );

  // R1 / R3: zero detection and mantissa product
  always_comb begin
    zero_d = (second_w[WORD_W-2:0] < (WORD_W-1)'(1 << FRAC_W)) ||
             (first_w[WORD_W-2:0] == '0);
    prod_d = PROD_W'(first_w[FRAC_W-1:0]) * PROD_W'({1'b1, second_w[FRAC_W-1:0]});
  end

  dnm_lead_norm u_lead (
    .prod  (prod_q),
    .found (found_w),
    .pos   (pos_w),
    .norm  (norm_w)
  );

  dnm_pack u_pack (
    .sgn        (a_q[WORD_W-1] ^ b_q[WORD_W-1]),
    .force_zero (zero_q),
    .found      (found_q),
    .base_exp   (b_q[WORD_W-2 -: EXP_W]),
    .pos        (pos_q),
    .norm       (norm_q),
    .res        (res_w)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    find_en = 1'b0;
    pack_en = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        load_en = 1'b1;
        st_d    = ST_FIND;
      end
      ST_FIND: begin
        find_en = 1'b1;
        st_d    = ST_PACK;
      end
      ST_PACK: begin
        pack_en = 1'b1;
        done_d  = 1'b1;
        st_d    = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (load_en) begin
      a_q    <= first_w;
      b_q    <= second_w;
      prod_q <= prod_d;
      zero_q <= zero_d;
    end
    if (find_en) begin
      found_q <= found_w;
      pos_q   <= pos_w;
      norm_q  <= norm_w;
    end
    if (pack_en) begin
      res_q <= res_w;
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy, 1) && $past(busy, 2)));

  a_r10_ops_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(a_q) && $stable(b_q)));

  a_r7_sign_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[WORD_W-1] == (a_q[WORD_W-1] ^ b_q[WORD_W-1])));

  a_r1_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zero_q) |-> (result[WORD_W-2:0] == '0));
endmodule

// File: tb/dnm_fmul_tb_top.sv
module dnm_fmul_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] op_a, op_b;
  logic        busy, done;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  dnm_fmul dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_a   (op_a),
    .op_b   (op_b),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {op_a, op_b, expected}
  localparam logic [95:0] VEC [15] = '{
    96'h00000001_3F800000_00000001, // R5 min subnormal x 1.0
    96'h00400000_40000000_00800000, // R4 result becomes normal
    96'h80400000_40000000_80800000, // R7 negative sign
    96'h00000000_3F800000_00000000, // R1 zero first operand
    96'h80000000_3F800000_80000000, // R1 signed zero
    96'h40000000_00400000_00800000, // R2 swapped order
    96'h00000001_00000002_00000000, // R1 both subnormal
    96'h00000001_3F000000_00000000, // R6 just past flush limit
    96'h00000001_BF000000_80000000, // R6 flush keeps sign
    96'h007FFFFF_7F7FFFFF_407FFFFD, // R4 R8 largest operands
    96'h00000003_7F000000_35400000, // R4 normal packing
    96'h00000003_3F800000_00000003, // R5 subnormal packing
    96'h3F800000_3F800000_00000000, // R3 zero fraction product
    96'h00000007_3F000000_00000003, // R8 truncation
    96'h00000001_00800000_00000000  // R6 smallest base exponent
  };

  function automatic logic [31:0] model(input logic [31:0] a_in, input logic [31:0] b_in);
    logic [31:0] a, b, mag;
    logic s;
    longint unsigned fx, fy, m;
    int e, w, ex, sh;
    if (a_in[30:0] >= 31'h00800000) begin a = b_in; b = a_in; end
    else begin a = a_in; b = b_in; end
    s = a[31] ^ b[31];
    if (b[30:0] < 31'h00800000 || a[30:0] == 31'h0) return {s, 31'h0};
    e  = int'(b[30:23]);
    fx = 64'(a[22:0]);
    fy = 64'({1'b1, b[22:0]});
    m  = fx * fy;
    if (m == 0) return {s, 31'h0};
    w = -1;
    for (longint unsigned n = m; n != 0; n = n >> 1) w++;
    ex = e + w - 126 - 46;
    if (ex > 0) begin
      mag = 32'((m >> (w - 23)) & 64'h7FFFFF) | 32'(ex << 23);
    end else if (ex + 22 >= 0) begin
      sh = w - 22 - ex;
      if (sh >= 0) mag = 32'((m >> sh) & 64'h7FFFFF);
      else         mag = 32'((m << (-sh)) & 64'h7FFFFF);
    end else begin
      mag = 32'h0;
    end
    return {s, mag[30:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] exp;
    exp = model(a, b);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", 32'(busy), 32'h1);
    check(done == 1'b0, "R9 no early done", 32'(done), 32'h0);
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b1, "R9 done after third edge", 32'(done), 32'h1);
    check(result == exp, tag, result, exp);
    @(negedge clk);
    check(done == 1'b0, "R9 done lasts one cycle", 32'(done), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] sub, nrm, exp;
    start = 1'b0; op_a = '0; op_b = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(busy == 1'b0, "R11 busy in reset", 32'(busy), 32'h0);
    check(done == 1'b0, "R11 done in reset", 32'(done), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      run_op(VEC[i][95:64], VEC[i][63:32], $sformatf("R4 R5 table vector %0d", i));
      check(result == VEC[i][31:0], $sformatf("table expected %0d", i), result, VEC[i][31:0]);
    end

    for (int i = 0; i < 300; i++) begin
      sub = {1'($urandom), 8'h00, 23'($urandom)};
      nrm = {1'($urandom), 8'(1 + $urandom % 254), 23'($urandom)};
      if ($urandom % 2) run_op(sub, nrm, "R4 R5 R6 random pair");
      else              run_op(nrm, sub, "R2 random swapped pair");
    end

    for (int e = 1; e < 256; e++) begin
      run_op({1'b0, 8'h00, 23'($urandom) | 23'h1}, {1'b1, 8'(e), 23'($urandom)},
             "R4 R5 R6 R7 exponent sweep");
    end

    // R10: start while busy is ignored
    exp = model(32'h00000003, 32'h3F800000);
    @(negedge clk);
    op_a = 32'h00000003; op_b = 32'h3F800000; start = 1'b1;
    @(negedge clk);
    op_a = 32'h00400000; op_b = 32'h40000000;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R10 no done mid-run", 32'(done), 32'h0);
    @(negedge clk);
    check(done == 1'b1, "R10 done of first op", 32'(done), 32'h1);
    check(result == exp, "R10 first result kept", result, exp);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R10 no second done", 32'(done), 32'h0);
      check(busy == 1'b0, "R10 no second run", 32'(busy), 32'h0);
    end
    check(result == exp, "R10 result holds", result, exp);

    // R11: reset in flight
    @(negedge clk);
    op_a = 32'h00000001; op_b = 32'h3F800000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R11 busy cleared", 32'(busy), 32'h0);
    check(done == 1'b0, "R11 done cleared", 32'(done), 32'h0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R11 aborted op silent", 32'(done), 32'h0);
    end
    run_op(32'h00000007, 32'h3F000000, "R8 after reset");

    summary();
  end
endmodule